// File: doc/BRIEF.md
# Multi-Window Priority Output Selector

This block resolves the replacement value for one centre pixel of an impulse-noise filter. Upstream logic evaluates four nested square windows around the same centre in parallel: 3x3, 5x5, 7x7 and 9x9. Each window delivers one lane to this block. A lane carries a candidate replacement value and a flag that is set when every pixel in that window was noisy. The block also receives the original centre value and its noise flag. It produces one output pixel per accepted centre position, in the order the positions arrive.

A clean centre passes through unchanged. A noisy centre takes the candidate from the smallest window that holds at least one usable pixel. This gives the effect of growing the window step by step, without a second pass over the data. When every window is fully noisy, the original centre value is kept and a sticky per-channel status bit records that the pixel could not be resolved. Colour data is carried as independent channels: each channel has its own centre, flags and candidates, and all channels share one set of lane valid strobes.

Top module: `mwin_prio_sel`

## Requirements
- R1: When all four lane valid bits are high at a clock edge, `out_vld` is high during the following cycle only, and `out_pix` carries the result for that input.
- R2: For a channel whose centre flag is 1 (noisy), the output is the candidate of the lowest-numbered lane whose all-noisy flag is 0. Lane l sits at bits [l*8 +: 8] of the channel's candidate group, and the lanes are numbered 0 = 3x3, 1 = 5x5, 2 = 7x7, 3 = 9x9.
- R3: For a channel whose centre flag is 0, the output equals that channel's centre value, whatever the lanes report.
- R4: When a noisy centre meets all four all-noisy flags set, the output equals the centre value and `out_unres` for that channel goes to 1. That bit stays at 1 until `rst_n` is low.
- R5: When some but not all lane valid bits are high at an edge, `out_err` is high in the next cycle, `out_vld` is low and `out_pix` keeps its value. When no valid bit is high, both `out_err` and `out_vld` are low in the next cycle.
- R6: Each selection uses only the inputs of its own cycle. Selection starts again from the 3x3 lane for every centre, whatever the window chosen for the previous pixel.
- R7: Channel c uses only its own inputs: centre bits [c*8 +: 8], centre flag bit c, candidates [c*32 +: 32] and all-noisy flags [c*4 +: 4]. Its result appears at `out_pix[c*8 +: 8]`.
- R8: `out_pix` keeps its value in every cycle that follows an edge with no accepted input.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_vld | input | 4 | Valid strobe per window lane, shared by all channels |
| lane_all_noisy | input | 12 | Per channel and lane: set when every pixel of that window is noisy |
| lane_cand | input | 96 | Per channel and lane: candidate replacement value |
| ctr_pix | input | 24 | Original centre value per channel |
| ctr_noisy | input | 3 | Centre noise flag per channel |
| out_vld | output | 1 | Output pixel valid |
| out_pix | output | 24 | Resolved pixel per channel |
| out_unres | output | 3 | Sticky per-channel flag: a pixel was left unresolved |
| out_err | output | 1 | Lane valid strobes were not aligned in the previous cycle |

## Verification
The assertions check on every cycle the properties that look at one cycle at a time: the one-cycle latency, the error response to misaligned strobes, holding the output when idle, the pass-through of a clean centre, the persistence of the unresolved bit, and that the granted lane never carries an all-noisy flag. Some behaviour needs a known sequence of inputs. Choosing the lowest usable lane, falling back to the centre when all lanes are noisy, starting again at 3x3 after a large-window pick, keeping the channels independent, and clearing the sticky bit on reset can only be shown by the bench's directed and seeded random scenarios, which are checked against a reference model.

// File: rtl/win_sel_pkg.sv
package win_sel_pkg;
    // Nested window lanes, smallest first: 3x3, 5x5, 7x7, 9x9.
    localparam int unsigned WIN_LANES = 4;
    localparam int unsigned PIX_W_DEF = 8;
    localparam int unsigned CH_DEF    = 3;

    // Side length of the square window served by a lane.
    function automatic int unsigned win_side(input int unsigned lane);
        return 3 + 2 * lane;
    endfunction
endpackage

// File: rtl/win_lane_check.sv
module win_lane_check #(
    parameter int unsigned LANES = win_sel_pkg::WIN_LANES
) (
    input  logic [LANES-1:0] vld,
    output logic             accept,
    output logic             mismatch
);
    always_comb begin
        accept   = &vld;
        mismatch = (|vld) & ~(&vld);
    end
endmodule

// File: rtl/win_prio_pick.sv
module win_prio_pick #(
    parameter int unsigned PIX_W = win_sel_pkg::PIX_W_DEF,
    parameter int unsigned LANES = win_sel_pkg::WIN_LANES
) (
    input  logic [LANES*PIX_W-1:0] cand,
    input  logic [LANES-1:0]       all_noisy,
    output logic [LANES-1:0]       grant,
    output logic [PIX_W-1:0]       pix,
    output logic                   none
);
    // Walk from the largest window down, so the smallest usable one wins last.
    always_comb begin
        grant = '0;
        pix   = '0;
        none  = 1'b1;
        for (int l = LANES - 1; l >= 0; l--) begin
            if (!all_noisy[l]) begin
                grant    = '0;
                grant[l] = 1'b1;
                pix      = cand[l*PIX_W +: PIX_W];
                none     = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mwin_prio_sel.sv
module mwin_prio_sel #(
    parameter int unsigned PIX_W  = win_sel_pkg::PIX_W_DEF,
    parameter int unsigned NUM_CH = win_sel_pkg::CH_DEF
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [win_sel_pkg::WIN_LANES-1:0]              lane_vld,
    input  logic [NUM_CH*win_sel_pkg::WIN_LANES-1:0]       lane_all_noisy,
    input  logic [NUM_CH*win_sel_pkg::WIN_LANES*PIX_W-1:0] lane_cand,
    input  logic [NUM_CH*PIX_W-1:0]                        ctr_pix,
    input  logic [NUM_CH-1:0]                              ctr_noisy,
    output logic                                           out_vld,
    output logic [NUM_CH*PIX_W-1:0]                        out_pix,
    output logic [NUM_CH-1:0]                              out_unres,
    output logic                                           out_err
);
    localparam int unsigned LANES = win_sel_pkg::WIN_LANES;
    localparam int unsigned GRP_W = LANES * PIX_W;

    typedef struct packed {
        logic                         vld;
        logic                         err;
        logic [NUM_CH-1:0]            unres;
        logic [NUM_CH-1:0][PIX_W-1:0] pix;
    } st_t;

    st_t st_d, st_q;

    logic                         accept, mismatch;
    logic [NUM_CH-1:0][LANES-1:0] pick_oh;
    logic [NUM_CH-1:0][PIX_W-1:0] pick_pix;
    logic [NUM_CH-1:0]            pick_none;

    win_lane_check #(.LANES(LANES)) u_chk (
        .vld      (lane_vld),
        .accept   (accept),
        .mismatch (mismatch)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        win_prio_pick #(.PIX_W(PIX_W), .LANES(LANES)) u_pick (
            .cand      (lane_cand[ch*GRP_W +: GRP_W]),
            .all_noisy (lane_all_noisy[ch*LANES +: LANES]),
            .grant     (pick_oh[ch]),
            .pix       (pick_pix[ch]),
            .none      (pick_none[ch])
        );

        // R2: a granted lane never has its all-noisy flag set
        a_r2_grant_usable: assert property (@(posedge clk) disable iff (!rst_n)
            (pick_oh[ch] & lane_all_noisy[ch*LANES +: LANES]) == '0);
        // R2: at most one lane granted
        a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pick_oh[ch]));
        // R3: a clean centre passes through one cycle later
        a_r3_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
            (&lane_vld && !ctr_noisy[ch]) |=>
            out_pix[ch*PIX_W +: PIX_W] == $past(ctr_pix[ch*PIX_W +: PIX_W]));
        // R4: the unresolved bit is sticky
        a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            out_unres[ch] |=> out_unres[ch]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = accept;
        st_d.err = mismatch;
        if (accept) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (!ctr_noisy[ch]) begin
                    st_d.pix[ch] = ctr_pix[ch*PIX_W +: PIX_W];
                end else if (pick_none[ch]) begin
                    st_d.pix[ch]   = ctr_pix[ch*PIX_W +: PIX_W];
                    st_d.unres[ch] = 1'b1;
                end else begin
                    st_d.pix[ch] = pick_pix[ch];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld   = st_q.vld;
    assign out_err   = st_q.err;
    assign out_unres = st_q.unres;
    assign out_pix   = st_q.pix;

    // R1: aligned lanes yield a valid output on the next cycle
    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (&lane_vld) |=> out_vld);
    // R5: partial strobes raise the error flag and suppress valid
    a_r5_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
        ((|lane_vld) && !(&lane_vld)) |=> (out_err && !out_vld));
    // R8: output pixel holds when nothing is accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(&lane_vld) |=> $stable(out_pix));
endmodule

// File: tb/tb_mwin_prio_sel.sv
module tb_mwin_prio_sel;
    localparam int PW = 8;
    localparam int NC = 3;
    localparam int NL = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NL-1:0]     lane_vld;
    logic [NC*NL-1:0]  lane_all_noisy;
    logic [NC*NL*PW-1:0] lane_cand;
    logic [NC*PW-1:0]  ctr_pix;
    logic [NC-1:0]     ctr_noisy;
    logic              out_vld;
    logic [NC*PW-1:0]  out_pix;
    logic [NC-1:0]     out_unres;
    logic              out_err;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [NC*PW-1:0] exp_pix;
    logic [NC-1:0]    exp_unres;
    logic             exp_vld, exp_err;

    always #2 clk = ~clk;

    mwin_prio_sel #(.PIX_W(PW), .NUM_CH(NC)) dut (
        .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld),
        .lane_all_noisy(lane_all_noisy), .lane_cand(lane_cand),
        .ctr_pix(ctr_pix), .ctr_noisy(ctr_noisy),
        .out_vld(out_vld), .out_pix(out_pix),
        .out_unres(out_unres), .out_err(out_err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    // Reference model: lowest usable lane of a noisy centre, else centre value.
    function automatic logic [PW-1:0] ref_pick(input int ch, output bit none);
        none = 1'b1;
        ref_pick = ctr_pix[ch*PW +: PW];
        if (!ctr_noisy[ch]) begin
            none = 1'b0;
            return ref_pick;
        end
        for (int l = 0; l < NL; l++) begin
            if (!lane_all_noisy[ch*NL + l]) begin
                none = 1'b0;
                return lane_cand[(ch*NL + l)*PW +: PW];
            end
        end
    endfunction

    // Inputs are already driven; clock once and compare at the following falling edge.
    task automatic step(input string tag);
        bit acc, none;
        logic [PW-1:0] v;
        acc = &lane_vld;
        exp_vld = acc;
        exp_err = (|lane_vld) && !acc;
        if (acc) begin
            for (int ch = 0; ch < NC; ch++) begin
                v = ref_pick(ch, none);
                exp_pix[ch*PW +: PW] = v;
                if (none) exp_unres[ch] = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(out_vld === exp_vld, {tag, " R1/R5 out_vld"}, out_vld, exp_vld);
        check(out_err === exp_err, {tag, " R5 out_err"}, out_err, exp_err);
        check(out_pix === exp_pix, {tag, " R2/R3/R7/R8 out_pix"}, out_pix, exp_pix);
        check(out_unres === exp_unres, {tag, " R4 out_unres"}, out_unres, exp_unres);
    endtask

    task automatic set_all(input logic [NL-1:0] an, input logic cn, input logic [PW-1:0] c0);
        lane_vld = '1;
        for (int ch = 0; ch < NC; ch++) begin
            lane_all_noisy[ch*NL +: NL] = an;
            ctr_noisy[ch] = cn;
            ctr_pix[ch*PW +: PW] = c0 + 8'(ch);
            for (int l = 0; l < NL; l++)
                lane_cand[(ch*NL + l)*PW +: PW] = 8'(16*(l+1) + ch);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        exp_pix = '0; exp_unres = '0; exp_vld = 1'b0; exp_err = 1'b0;
        check(out_vld === 1'b0 && out_err === 1'b0, "R9 reset flags", {out_vld, out_err}, 0);
        check(out_pix === '0, "R9 reset pix", out_pix, 0);
        check(out_unres === '0, "R9 reset unres", out_unres, 0);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        lane_vld = '0; lane_all_noisy = '0; lane_cand = '0; ctr_pix = '0; ctr_noisy = '0;
        @(negedge clk);
        do_reset();

        // R3: clean centre passes even though lanes are usable
        set_all(4'b0000, 1'b0, 8'h41); step("R3 clean centre");
        // R2: noisy centre, 3x3 usable
        set_all(4'b0000, 1'b1, 8'hFF); step("R2 lane0");
        // R2: 3x3 fully noisy, 5x5 usable
        set_all(4'b0001, 1'b1, 8'h00); step("R2 lane1");
        // R2: only 9x9 usable
        set_all(4'b0111, 1'b1, 8'hFF); step("R2 lane3");
        // R6: next pixel restarts at 3x3
        set_all(4'b1010, 1'b1, 8'h00); step("R6 restart at 3x3");
        // R8: idle, output held
        lane_vld = '0; lane_cand = ~lane_cand; step("R8 idle hold");
        // R5: misaligned strobes
        set_all(4'b0000, 1'b1, 8'h00); lane_vld = 4'b1011; step("R5 mismatch");
        lane_vld = 4'b0001; step("R5 single lane");
        // R4: all windows noisy keeps the centre and sets the sticky bit on channel 1 only (R7)
        set_all(4'b0000, 1'b1, 8'h20);
        lane_all_noisy[1*NL +: NL] = 4'b1111;
        lane_all_noisy[2*NL +: NL] = 4'b1101;
        step("R4 R7 unresolved ch1");
        // R4: sticky bit persists through clean pixels
        set_all(4'b0000, 1'b0, 8'h33); step("R4 sticky persists");
        // R9: reset clears the sticky bit
        lane_vld = '0;
        do_reset();

        // Seeded random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(99);
            lane_vld = (r < 85) ? 4'hF : 4'($urandom);
            for (int ch = 0; ch < NC; ch++) begin
                ctr_noisy[ch] = ($urandom_range(99) < 70);
                ctr_pix[ch*PW +: PW] = ctr_noisy[ch] ? (($urandom_range(1) != 0) ? 8'hFF : 8'h00)
                                                     : 8'($urandom_range(254, 1));
                for (int l = 0; l < NL; l++) begin
                    lane_all_noisy[ch*NL + l] = ($urandom_range(99) < 55 - 10*l);
                    lane_cand[(ch*NL + l)*PW +: PW] = 8'($urandom);
                end
            end
            step("R1 R2 R6 R7 random");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule